// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller Front-End

This block is the register side of an eight-input interrupt controller of the kind found in older PC designs. A host writes and reads it one byte at a time through two port addresses: an even one and an odd one. A command on the even port with data bit 4 set starts initialization. The setup words that follow all arrive on the odd port. The block steers each odd-port write by sequencer state. While setup is under way, a write becomes the next setup word. Once setup has finished, it becomes the interrupt mask.

After setup, the block captures rising edges on its request lines into a request register. It picks the most urgent unmasked request under fixed priority, with line 0 the most urgent. It raises one interrupt output when that request outranks every level already in service. A one-cycle acknowledge pulse moves the chosen request into the in-service register and latches the vector for that line. The vector is the upper bits of the base word with the line number in the low bits. An in-service level is freed either by an explicit end-of-interrupt command or automatically at acknowledge, depending on the mode word.

Top module: `pic_front`

## Requirements
- R1: After reset the mask reads 00h, the request and in-service registers read 00h, and the interrupt output is low. The device is uninitialized. Automatic end-of-interrupt and special nesting are off, which matches a mode word of 01h.
- R2: An even-port write with data bit 4 set is the start word. It clears the mask and the in-service register, sets even-port reads back to the request register, and restarts setup. The interrupt output stays low until the final setup word has been written.
- R3: After the start word, odd-port writes are taken in order as the base word, then the slave identity word, then the mode word. The slave identity word is skipped when bit 1 of the start word is 1. Odd-port writes during setup, or before any start word, leave the mask unchanged.
- R4: Once setup has finished, an odd-port write loads the mask from the data byte, with bit n masking line n. An odd-port read returns the mask with no prior select command.
- R5: A rising edge on line n sets request bit n. A masked request never raises the interrupt output. Masking a line has no effect on lines of lower priority.
- R6: Priority is fixed, with line 0 highest and line 7 lowest. In the default nesting mode, the output is high only when the highest unmasked pending request is strictly more urgent than every in-service bit.
- R7: An acknowledge pulse takes the highest unmasked pending request. It clears that request bit and sets the matching in-service bit. On the next cycle the vector output holds base word bits 7:3 above the 3-bit line number.
- R8: When mode-word bit 1 is 1 (automatic end-of-interrupt), an acknowledge pulse sets no in-service bit.
- R9: An even-port write of 20h (bits 7:5 = 001, bits 4:3 = 00) is a non-specific end-of-interrupt command. It clears the most urgent set in-service bit.
- R10: An even-port write with bit 4 = 0 and bit 3 = 1 is a read-select command. With bits 1:0 = 10, later even-port reads return the request register. With bits 1:0 = 11, they return the in-service register.
- R11: When mode-word bit 4 is 1 (special nesting), a request at the same level as the most urgent in-service bit also raises the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr_odd | input | 1 | Port select, 1 for odd port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when no read |
| irq_in | input | 8 | Interrupt request lines |
| ack | input | 1 | One-cycle acknowledge pulse |
| intr | output | 1 | Interrupt output |
| vec | output | 8 | Vector of the last acknowledged line |

## Verification
Two conditions are the hardest to reach from the ports. The first is a nested in-service state in which a newer, more urgent request is accepted on top of an older one. It is built by raising a lower line and acknowledging it, then raising a higher one and a lower one. End-of-interrupt commands then release the levels one at a time, with in-service reads confirming each release. The second is the shortened setup without the slave identity word. It is reached from a fresh reset, and the bench shows where each odd-port write went by reading back the mask once setup has finished.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [2:0] {
      SEQ_IDLE,
      SEQ_BASE,
      SEQ_SLAVE,
      SEQ_MODE,
      SEQ_READY
   } seq_t;

   localparam int BIT_START  = 4;
   localparam int BIT_SELECT = 3;
   localparam int BIT_SINGLE = 1;
   localparam int BIT_AUTO   = 1;
   localparam int BIT_SPECL  = 4;
   localparam logic [2:0] EOI_NONSPEC = 3'b001;
endpackage

// File: rtl/pic_seq.sv
module pic_seq
   import pic_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          addr_odd,
   input  logic [DW-1:0] wdata,
   output logic          start_stb,
   output logic          ready,
   output logic          mask_wr,
   output logic          eoi_cmd,
   output logic          sel_wr,
   output logic [DW-1:0] base,
   output logic          auto_eoi,
   output logic          specl
);
   seq_t state;
   logic single;
   logic odd_wr;

   assign odd_wr    = wr_en & addr_odd;
   assign start_stb = wr_en & ~addr_odd & wdata[BIT_START];
   assign ready     = (state == SEQ_READY);
   assign mask_wr   = odd_wr & ready;
   assign sel_wr    = wr_en & ~addr_odd & ready & ~wdata[BIT_START] & wdata[BIT_SELECT];
   assign eoi_cmd   = wr_en & ~addr_odd & ready & ~wdata[BIT_START] & ~wdata[BIT_SELECT]
                      & (wdata[7:5] == EOI_NONSPEC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SEQ_IDLE;
         single   <= 1'b0;
         base     <= '0;
         auto_eoi <= 1'b0;
         specl    <= 1'b0;
      end else if (start_stb) begin
         state  <= SEQ_BASE;
         single <= wdata[BIT_SINGLE];
      end else if (odd_wr) begin
         unique case (state)
            SEQ_BASE: begin
               base  <= wdata;
               state <= single ? SEQ_MODE : SEQ_SLAVE;
            end
            SEQ_SLAVE: state <= SEQ_MODE;
            SEQ_MODE: begin
               auto_eoi <= wdata[BIT_AUTO];
               specl    <= wdata[BIT_SPECL];
               state    <= SEQ_READY;
            end
            default: state <= state;
         endcase
      end
   end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
   parameter int N = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   assign found = |req;

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/pic_front.sv
module pic_front
   import pic_pkg::*;
#(
   parameter int NLINES    = 8,
   parameter int DW        = 8,
   parameter bit EDGE_TRIG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic          addr_odd,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic [NLINES-1:0] irq_in,
   input  logic          ack,
   output logic          intr,
   output logic [DW-1:0] vec
);
   localparam int IW = (NLINES > 1) ? $clog2(NLINES) : 1;

   if (NLINES < 2 || NLINES > DW) begin : g_bad_lines
      $error("pic_front: NLINES must be between 2 and DW");
   end
   if (DW < 8) begin : g_bad_width
      $error("pic_front: command decode needs DW of at least 8");
   end

   logic start_stb, ready, mask_wr, eoi_cmd, sel_wr, auto_eoi, specl;
   logic [DW-1:0] base;
   logic [NLINES-1:0] imr, irr, isr, pend, take_oh, eoi_oh;
   logic p_found, i_found, blocked, take, rd_isr;
   logic [IW-1:0] p_idx, i_idx;

   pic_seq #(.DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_odd(addr_odd),
      .wdata(wdata), .start_stb(start_stb), .ready(ready), .mask_wr(mask_wr),
      .eoi_cmd(eoi_cmd), .sel_wr(sel_wr), .base(base),
      .auto_eoi(auto_eoi), .specl(specl)
   );

   assign pend = irr & ~imr;

   pic_prio #(.N(NLINES)) u_pend (.req(pend), .found(p_found), .idx(p_idx));
   pic_prio #(.N(NLINES)) u_isr  (.req(isr),  .found(i_found), .idx(i_idx));

   assign blocked = i_found & (specl ? (i_idx < p_idx) : (i_idx <= p_idx));
   assign intr    = ready & p_found & ~blocked;
   assign take    = ack & ready & p_found;
   assign take_oh = take ? (NLINES'(1) << p_idx) : '0;
   assign eoi_oh  = (eoi_cmd & i_found) ? (NLINES'(1) << i_idx) : '0;

   if (EDGE_TRIG) begin : g_edge
      logic [NLINES-1:0] prev;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev <= '0;
            irr  <= '0;
         end else begin
            prev <= irq_in;
            irr  <= (irr & ~take_oh) | (irq_in & ~prev);
         end
      end
   end else begin : g_level
      always_ff @(posedge clk) begin
         if (!rst_n) irr <= '0;
         else        irr <= irq_in;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imr    <= '0;
         isr    <= '0;
         rd_isr <= 1'b0;
         vec    <= '0;
      end else begin
         if (start_stb) begin
            imr    <= '0;
            isr    <= '0;
            rd_isr <= 1'b0;
         end else begin
            if (mask_wr) imr <= wdata[NLINES-1:0];
            isr <= (isr & ~eoi_oh) | (auto_eoi ? '0 : take_oh);
            if (sel_wr && wdata[1]) rd_isr <= wdata[0];
         end
         if (take) vec <= {base[DW-1:IW], p_idx};
      end
   end

   always_comb begin
      if (!rd_en)        rdata = '0;
      else if (addr_odd) rdata = DW'(imr);
      else if (rd_isr)   rdata = DW'(isr);
      else               rdata = DW'(irr);
   end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
   parameter int NLINES = 8,
   parameter int DW     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              addr_odd,
   input logic [DW-1:0]     wdata,
   input logic              ack,
   input logic              intr,
   input logic              ready,
   input logic              auto_eoi,
   input logic              start_stb,
   input logic [NLINES-1:0] irr,
   input logic [NLINES-1:0] imr,
   input logic [NLINES-1:0] isr
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !intr); // R2

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_stb |=> (imr == '0 && isr == '0)); // R2

   AST_MASK_HELD_IN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr_odd && !ready) |=> $stable(imr)); // R3

   AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      intr |-> ((irr & ~imr) != '0)); // R5

   AST_ACK_ONE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && ready && !auto_eoi) |=> ($countones(isr & ~$past(isr)) <= 1)); // R7

   AST_AUTO_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && auto_eoi) |=> ((isr & ~$past(isr)) == '0)); // R8

   AST_SERVICE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |=> ((isr & ~$past(isr)) == '0)); // R7
endmodule

bind pic_front pic_chk #(.NLINES(NLINES), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_odd(addr_odd), .wdata(wdata),
   .ack(ack), .intr(intr), .ready(ready), .auto_eoi(auto_eoi),
   .start_stb(start_stb), .irr(irr), .imr(imr), .isr(isr)
);

// File: tb/tb_pic_front.sv
module tb_pic_front;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, addr_odd = 1'b0, ack = 1'b0;
   logic [7:0] wdata = '0, irq = '0;
   logic [7:0] rdata, vec;
   logic       intr;
   int         checks = 0, errors = 0, cycles = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   pic_front dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr_odd(addr_odd),
      .wdata(wdata), .rdata(rdata), .irq_in(irq), .ack(ack), .intr(intr), .vec(vec)
   );

   // row: op(2) odd(1) data(8) irq(8) ack(1) exp_rd(8) exp_intr(1) tag(4)
   // op 0 idle, 1 write, 2 read
   localparam int NROWS = 20;
   localparam logic [32:0] TBL [NROWS] = '{
      {2'd1,1'b0,8'h11,8'h00,1'b0,8'h00,1'b0,4'd2},  // R2 start word
      {2'd1,1'b1,8'h40,8'h00,1'b0,8'h00,1'b0,4'd3},  // R3 base
      {2'd1,1'b1,8'h02,8'h00,1'b0,8'h00,1'b0,4'd3},  // R3 slave id
      {2'd1,1'b1,8'h01,8'h00,1'b0,8'h00,1'b0,4'd3},  // R3 mode
      {2'd2,1'b1,8'h00,8'h00,1'b0,8'h00,1'b0,4'd4},  // R4 mask read
      {2'd1,1'b1,8'h05,8'h00,1'b0,8'h00,1'b0,4'd4},  // R4 mask 0,2
      {2'd0,1'b0,8'h00,8'h05,1'b0,8'h00,1'b0,4'd5},  // R5 masked lines
      {2'd0,1'b0,8'h00,8'h0D,1'b0,8'h00,1'b1,4'd5},  // R5 lower line passes
      {2'd2,1'b0,8'h00,8'h0D,1'b0,8'h0D,1'b1,4'd10}, // R10 default request read
      {2'd0,1'b0,8'h00,8'h0D,1'b1,8'h00,1'b0,4'd7},  // R7 ack line 3
      {2'd1,1'b0,8'h0B,8'h0D,1'b0,8'h00,1'b0,4'd10}, // R10 select service
      {2'd2,1'b0,8'h00,8'h0D,1'b0,8'h08,1'b0,4'd7},  // R7 service bit 3
      {2'd0,1'b0,8'h00,8'h2D,1'b0,8'h00,1'b0,4'd6},  // R6 line 5 blocked
      {2'd0,1'b0,8'h00,8'h2F,1'b0,8'h00,1'b1,4'd6},  // R6 line 1 nests
      {2'd0,1'b0,8'h00,8'h2F,1'b1,8'h00,1'b0,4'd7},  // R7 ack line 1
      {2'd1,1'b0,8'h20,8'h2F,1'b0,8'h00,1'b0,4'd9},  // R9 release 1
      {2'd2,1'b0,8'h00,8'h2F,1'b0,8'h08,1'b0,4'd9},  // R9 bit 3 left
      {2'd1,1'b0,8'h20,8'h2F,1'b0,8'h00,1'b1,4'd9},  // R9 release 3
      {2'd1,1'b1,8'h20,8'h2F,1'b0,8'h00,1'b1,4'd4},  // R4 new mask
      {2'd2,1'b1,8'h00,8'h2F,1'b0,8'h20,1'b1,4'd4}   // R4 mask readback
   };

   task automatic chk(input int tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic odd, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr_odd = odd; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input int tag, input logic odd, input logic [7:0] exp);
      @(negedge clk);
      rd_en = 1'b1; addr_odd = odd;
      #1 chk(tag, rdata, exp);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic set_irq(input logic [7:0] v);
      @(negedge clk);
      irq = v;
      @(negedge clk);
   endtask

   task automatic pulse_ack();
      @(negedge clk);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; irq = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++; errors++;
         $display("FAIL watchdog actual %0d expected below 20000", cycles);
         finish_up();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(1, {7'd0, intr}, 8'h00);
      rd_chk(1, 1'b1, 8'h00);
      rd_chk(1, 1'b0, 8'h00);

      for (int r = 0; r < NROWS; r++) begin
         logic [32:0] row;
         row = TBL[r];
         wr_en = (row[32:31] == 2'd1);
         rd_en = (row[32:31] == 2'd2);
         addr_odd = row[30]; wdata = row[29:22]; irq = row[21:14]; ack = row[13];
         #1;
         if (row[32:31] == 2'd2) chk(int'(row[3:0]), rdata, row[12:5]);
         @(negedge clk);
         chk(int'(row[3:0]), {7'd0, intr}, {7'd0, row[4]});
      end
      wr_en = 1'b0; rd_en = 1'b0; ack = 1'b0;
      chk(7, vec, 8'h41); // R7 vector of line 1 on base 40h

      // R1 after a fresh reset
      do_reset();
      chk(1, {7'd0, intr}, 8'h00);
      rd_chk(1, 1'b1, 8'h00);

      // R2 uninitialized device stays quiet, R3 odd write ignored
      set_irq(8'h01);
      chk(2, {7'd0, intr}, 8'h00);
      wr(1'b1, 8'h55);
      rd_chk(3, 1'b1, 8'h00);

      // R3 shortened setup without slave word, automatic EOI mode
      wr(1'b0, 8'h13);
      wr(1'b1, 8'h08);
      rd_chk(3, 1'b1, 8'h00);
      wr(1'b1, 8'h03);
      chk(3, {7'd0, intr}, 8'h01);
      wr(1'b1, 8'hF0);
      rd_chk(3, 1'b1, 8'hF0);
      pulse_ack();
      chk(7, vec, 8'h08);
      chk(7, {7'd0, intr}, 8'h00);
      wr(1'b0, 8'h0B);
      rd_chk(8, 1'b0, 8'h00); // R8 no service bit
      set_irq(8'h03);
      chk(8, {7'd0, intr}, 8'h01); // R8 line 1 not blocked by line 0
      pulse_ack();
      chk(7, vec, 8'h09);

      // R11 special nesting lets the same level through
      do_reset();
      wr(1'b0, 8'h13);
      wr(1'b1, 8'h00);
      wr(1'b1, 8'h11);
      set_irq(8'h04);
      chk(11, {7'd0, intr}, 8'h01);
      pulse_ack();
      chk(11, {7'd0, intr}, 8'h00);
      set_irq(8'h00);
      set_irq(8'h04);
      chk(11, {7'd0, intr}, 8'h01);

      // R2 start word clears mask and service, resets read select
      wr(1'b1, 8'h0F);
      rd_chk(4, 1'b1, 8'h0F);
      wr(1'b0, 8'h13);
      rd_chk(2, 1'b1, 8'h00);
      rd_chk(2, 1'b0, 8'h04);
      chk(2, {7'd0, intr}, 8'h00);
      wr(1'b1, 8'h00);
      wr(1'b1, 8'h01);
      chk(2, {7'd0, intr}, 8'h01);
      wr(1'b0, 8'h0B);
      rd_chk(2, 1'b0, 8'h00);

      finish_up();
   end
endmodule